// File: doc/BRIEF.md
# Trigger-Paced Descriptor-Chain Copy Channel

This block is one memory-to-memory copy channel that follows a chain of descriptors kept in a small local descriptor store. Each descriptor names a source word address, a destination word address, a length in words and the index of the next descriptor. Index 0 means "no successor". After a start pulse the channel loads the head descriptor and then waits. It copies one block only when the selected upstream completion line pulses. It does this one block per pulse until it reaches a descriptor whose successor is 0.

Once every block has been copied, the channel writes a programmed mask word to a programmed address. This lets it clear the upstream completion flag by itself, so the channel paces itself against another DMA that fills a shared buffer. A chain whose last descriptor points back into the chain runs forever and completes only when aborted. If the upstream source stops pulsing, the channel waits without touching memory. The memory side is a single request port: reads return data one cycle after the request, and writes take effect on the request edge.

Top module: `lldma_chain`

## Requirements
- R1: After reset busy, complete and overrun are 0 and mem_req is 0.
- R2: A start pulse while idle makes busy 1 and loads descriptor head_ptr. No memory access happens until a trigger arrives, and the channel waits indefinitely while triggers are absent.
- R3: A block of length L reads source+i and then writes the returned word to dest+i, for i = 0 to L-1 in order.
- R4: Only a rising edge on trig_in[trig_idx] is a trigger. Pulses on the other 15 lines have no effect.
- R5: After the last data write of a block, the channel issues exactly one write of ack_mask to ack_addr. This write comes before any data access of the next block.
- R6: After each block the channel moves to the descriptor given by the next field. When that field is 0, complete becomes 1 in the cycle after the acknowledge write and busy becomes 0. complete stays 1 until the next start.
- R7: When the chain links back to an earlier descriptor, complete never becomes 1 and every trigger keeps producing one block.
- R8: A trigger that arrives while a block is in progress is held as pending. The next block then runs without any further trigger.
- R9: A trigger that arrives while one is already pending sets overrun. overrun stays 1 until the next start.
- R10: abort returns the channel to idle from any state, clears the pending trigger and stops all memory access.
- R11: A descriptor with length 0 produces only the acknowledge write, with no data access.
- R12: Triggers that arrive while the channel is idle are discarded and do not start a block after a later start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin walking the chain at head_ptr (ignored when busy) |
| abort | input | 1 | Return to idle at once |
| head_ptr | input | 3 | Index of the first descriptor |
| trig_idx | input | 4 | Selects which trigger line paces the channel |
| trig_in | input | 16 | Upstream completion lines |
| ack_addr | input | 16 | Address that receives the acknowledge write |
| ack_mask | input | 32 | Word written to ack_addr after each block |
| dwr_en | input | 1 | Descriptor store write enable |
| dwr_idx | input | 3 | Descriptor index to write |
| dwr_src | input | 16 | Source word address field |
| dwr_dst | input | 16 | Destination word address field |
| dwr_len | input | 8 | Length field in words |
| dwr_next | input | 3 | Next-descriptor field, 0 ends the chain |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| busy | output | 1 | Channel active |
| complete | output | 1 | Chain ended at a null link |
| overrun | output | 1 | A trigger arrived while another was pending |

## Verification
The assertions check, on every cycle, that the channel is silent on memory while idle or while waiting without a trigger, and that each data write follows a read. They also check that abort lands in idle with nothing pending, that complete rises only right after an acknowledge write, and that overrun rises only when a trigger was already pending. Only the bench scenarios can show the things that depend on whole sequences. These are the copied data values, the position of each acknowledge write relative to the data writes, and which trigger lines are ignored. They also include a looping chain that never completes, a zero-length block, and triggers that are discarded while idle or by abort.

// File: rtl/lldma_pkg.sv
// Shared sizes and types for the descriptor-chain copy channel.
package lldma_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 8;
    localparam int DESC_N = 8;
    localparam int PTR_W  = $clog2(DESC_N);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  len;
        logic [PTR_W-1:0]  nxt;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_WAIT, ST_RD, ST_WR, ST_ACK
    } state_t;
endpackage

// File: rtl/lldma_desc_store.sv
// Descriptor store: DESC_N register entries, one write port, one
// combinational read port. Assumes writes happen while the channel is idle.
module lldma_desc_store
    import lldma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  desc_t            wr_desc,
    input  logic [PTR_W-1:0] rd_idx,
    output desc_t            rd_desc
);
    desc_t entry [DESC_N];

    for (genvar g = 0; g < DESC_N; g++) begin : g_entry
        // Hold one descriptor, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry[g] <= '0;
            else if (wr_en && wr_idx == PTR_W'(g))
                entry[g] <= wr_desc;
        end
    end

    assign rd_desc = entry[rd_idx];
endmodule

// File: rtl/lldma_trig.sv
// Trigger front end: selects one of NTRIG lines, detects its rising
// edge, and holds one pending trigger. A further trigger while one is
// already pending sets a sticky overrun. Assumes sel is stable while en.
module lldma_trig #(
    parameter int NTRIG = 16,
    localparam int SEL_W = $clog2(NTRIG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             flush,
    input  logic             clr_ovr,
    input  logic             consume,
    input  logic [SEL_W-1:0] sel,
    input  logic [NTRIG-1:0] lines,
    output logic             pending,
    output logic             overrun
);
    logic prev_q;
    logic edge_w;

    assign edge_w = en && lines[sel] && !prev_q;

    // Remember the previous level of the selected line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lines[sel];
    end

    // Pending trigger: set on an edge, cleared when consumed, flushed or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || flush || !en) pending <= 1'b0;
        else                        pending <= (pending && !consume) || edge_w;
    end

    // Sticky overrun when an edge meets an unconsumed pending trigger.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_ovr)                 overrun <= 1'b0;
        else if (edge_w && pending && !consume) overrun <= 1'b1;
    end

    a_r9_overrun_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(pending));
    a_r12_idle_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pending);
endmodule

// File: rtl/lldma_engine.sv
// Channel sequencer: fetches a descriptor, waits for a pending trigger,
// copies the block word by word (read, then write), writes the
// acknowledge mask, and follows the next link until it is 0.
// Assumes read data returns one cycle after a read request.
module lldma_engine
    import lldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [PTR_W-1:0]  head_ptr,
    input  logic [ADDR_W-1:0] ack_addr,
    input  logic [DATA_W-1:0] ack_mask,
    input  logic              pending,
    output logic              consume,
    output logic [PTR_W-1:0]  desc_idx,
    input  desc_t             desc_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              complete
);
    state_t           state;
    desc_t            cur;
    logic [PTR_W-1:0] ptr;
    logic [LEN_W-1:0] cnt;
    logic             last_word;

    assign busy      = (state != ST_IDLE);
    assign desc_idx  = ptr;
    assign consume   = (state == ST_WAIT) && pending;
    assign last_word = (LEN_W'(cnt + 1'b1) == cur.len);

    // Main state sequence with abort taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (start) state <= ST_FETCH;
                ST_FETCH: state <= ST_WAIT;
                ST_WAIT:  if (pending) state <= (cur.len == '0) ? ST_ACK : ST_RD;
                ST_RD:    state <= ST_WR;
                ST_WR:    state <= last_word ? ST_ACK : ST_RD;
                ST_ACK:   state <= (cur.nxt == '0) ? ST_IDLE : ST_FETCH;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Descriptor pointer and working copy of the current descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            cur <= '0;
        end else begin
            if (state == ST_IDLE && start) ptr <= head_ptr;
            else if (state == ST_ACK)      ptr <= cur.nxt;
            if (state == ST_FETCH)         cur <= desc_in;
        end
    end

    // Word counter within the current block.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_FETCH) cnt <= '0;
        else if (state == ST_WR)         cnt <= cnt + 1'b1;
    end

    // Completion flag: set at a null link, cleared by start or abort.
    always_ff @(posedge clk) begin
        if (!rst_n || abort)                            complete <= 1'b0;
        else if (state == ST_IDLE && start)             complete <= 1'b0;
        else if (state == ST_ACK && cur.nxt == '0)      complete <= 1'b1;
    end

    // Memory port drive per state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = cur.src + ADDR_W'(cnt);
            end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur.dst + ADDR_W'(cnt);
                mem_wdata = mem_rdata;
            end
            ST_ACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ack_addr;
                mem_wdata = ack_mask;
            end
            default: ;
        endcase
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
    a_r2_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !pending && !abort) |=> !mem_req);
    a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR) |-> $past(mem_req && !mem_we));
    a_r6_complete_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(complete) |-> $past(mem_req && mem_we && mem_addr == ack_addr && mem_wdata == ack_mask));
    a_r10_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy && !mem_req);
endmodule

// File: rtl/lldma_chain.sv
// Top: descriptor store, trigger front end and sequencer of one
// trigger-paced descriptor-chain copy channel.
module lldma_chain
    import lldma_pkg::*;
#(
    parameter int NTRIG = 16,
    localparam int SEL_W = $clog2(NTRIG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [PTR_W-1:0]  head_ptr,
    input  logic [SEL_W-1:0]  trig_idx,
    input  logic [NTRIG-1:0]  trig_in,
    input  logic [ADDR_W-1:0] ack_addr,
    input  logic [DATA_W-1:0] ack_mask,
    input  logic              dwr_en,
    input  logic [PTR_W-1:0]  dwr_idx,
    input  logic [ADDR_W-1:0] dwr_src,
    input  logic [ADDR_W-1:0] dwr_dst,
    input  logic [LEN_W-1:0]  dwr_len,
    input  logic [PTR_W-1:0]  dwr_next,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              complete,
    output logic              overrun
);
    desc_t            wr_desc;
    desc_t            rd_desc;
    logic [PTR_W-1:0] rd_idx;
    logic             pending;
    logic             consume;
    logic             start_ok;

    assign wr_desc  = '{src: dwr_src, dst: dwr_dst, len: dwr_len, nxt: dwr_next};
    assign start_ok = start && !busy;

    lldma_desc_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dwr_en),
        .wr_idx  (dwr_idx),
        .wr_desc (wr_desc),
        .rd_idx  (rd_idx),
        .rd_desc (rd_desc)
    );

    lldma_trig #(.NTRIG(NTRIG)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (busy),
        .flush   (abort),
        .clr_ovr (start_ok),
        .consume (consume),
        .sel     (trig_idx),
        .lines   (trig_in),
        .pending (pending),
        .overrun (overrun)
    );

    lldma_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (abort),
        .head_ptr  (head_ptr),
        .ack_addr  (ack_addr),
        .ack_mask  (ack_mask),
        .pending   (pending),
        .consume   (consume),
        .desc_idx  (rd_idx),
        .desc_in   (rd_desc),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .complete  (complete)
    );
endmodule

// File: tb/tb_lldma_chain.sv
// Directed bench: a word memory model with one-cycle read latency,
// an acknowledge monitor, and one task per scenario.
module tb_lldma_chain;
    localparam logic [15:0] ACK_A = 16'h0F00;
    localparam logic [31:0] MASK  = 32'h0000_0020;
    localparam int TSEL = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, abort = 1'b0;
    logic [2:0]  head_ptr = '0;
    logic [3:0]  trig_idx = 4'(TSEL);
    logic [15:0] trig_in = '0;
    logic        dwr_en = 1'b0;
    logic [2:0]  dwr_idx = '0, dwr_next = '0;
    logic [15:0] dwr_src = '0, dwr_dst = '0;
    logic [7:0]  dwr_len = '0;
    logic        mem_req, mem_we, busy, complete, overrun;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    int checks = 0, errors = 0;
    int data_wr = 0, acks = 0, bad_mask = 0;
    int ack_at [64];
    logic [31:0] mem [256];

    always #4 clk = ~clk;

    lldma_chain dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .head_ptr(head_ptr), .trig_idx(trig_idx), .trig_in(trig_in),
        .ack_addr(ACK_A), .ack_mask(MASK),
        .dwr_en(dwr_en), .dwr_idx(dwr_idx), .dwr_src(dwr_src),
        .dwr_dst(dwr_dst), .dwr_len(dwr_len), .dwr_next(dwr_next),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .complete(complete), .overrun(overrun)
    );

    // Memory model and acknowledge monitor.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= (i < 128) ? (32'hA000_0000 | i) : 32'h0;
            mem_rdata <= '0;
        end else if (mem_req && mem_we) begin
            if (mem_addr == ACK_A) begin
                if (mem_wdata != MASK) bad_mask++;
                if (acks < 64) ack_at[acks] = data_wr;
                acks++;
            end else begin
                mem[mem_addr[7:0]] <= mem_wdata;
                data_wr++;
            end
        end else if (mem_req) begin
            mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_desc(input int idx, input int s, input int d, input int l, input int n);
        @(negedge clk);
        dwr_en = 1'b1; dwr_idx = 3'(idx); dwr_src = 16'(s);
        dwr_dst = 16'(d); dwr_len = 8'(l); dwr_next = 3'(n);
        @(negedge clk);
        dwr_en = 1'b0;
    endtask

    task automatic go(input int head);
        @(negedge clk);
        head_ptr = 3'(head); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        trig_in[line] = 1'b1;
        @(negedge clk);
        trig_in[line] = 1'b0;
    endtask

    task automatic kill();
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
    endtask

    task automatic wait_acks(input int target);
        for (int i = 0; i < 400 && acks < target; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 complete", complete, 0);
        check("R1 overrun", overrun, 0);
        check("R1 mem_req", mem_req, 0);
    endtask

    task automatic t_idle_trigger();
        int w0;
        put_desc(1, 8'h10, 8'h80, 2, 0);
        w0 = data_wr;
        pulse(TSEL);
        repeat (3) @(negedge clk);
        go(1);
        repeat (30) @(negedge clk);
        check("R12 idle trigger dropped", data_wr - w0, 0);
        check("R2 busy while waiting", busy, 1);
        kill();
    endtask

    task automatic t_chain();
        int w0, a0;
        put_desc(1, 8'h10, 8'h80, 4, 2);
        put_desc(2, 8'h20, 8'h90, 2, 3);
        put_desc(3, 8'h30, 8'hA0, 0, 0);
        w0 = data_wr; a0 = acks;
        go(1);
        for (int i = 0; i < 16; i++) if (i != TSEL) pulse(i);
        repeat (40) @(negedge clk);
        check("R2 stall without trigger", data_wr - w0, 0);
        check("R4 other lines ignored", acks - a0, 0);
        pulse(TSEL);
        wait_acks(a0 + 1);
        for (int i = 0; i < 4; i++) check("R3 block data", mem[8'h80 + i], 32'hA000_0010 + i);
        check("R5 ack after last write", ack_at[a0], w0 + 4);
        check("R6 not complete mid chain", complete, 0);
        pulse(TSEL);
        wait_acks(a0 + 2);
        for (int i = 0; i < 2; i++) check("R3 second block", mem[8'h90 + i], 32'hA000_0020 + i);
        check("R5 second ack position", ack_at[a0 + 1], w0 + 6);
        pulse(TSEL);
        wait_acks(a0 + 3);
        check("R11 zero length no data", data_wr - w0, 6);
        check("R11 zero length acked", acks - a0, 3);
        check("R6 complete", complete, 1);
        check("R6 busy drops", busy, 0);
        check("R5 ack mask value", bad_mask, 0);
        check("R6 untouched past end", mem[8'hA0], 0);
    endtask

    task automatic t_loop();
        int w0, a0;
        put_desc(4, 8'h40, 8'hB0, 2, 5);
        put_desc(5, 8'h44, 8'hB4, 2, 4);
        w0 = data_wr; a0 = acks;
        go(4);
        check("R6 start clears complete", complete, 0);
        for (int k = 0; k < 5; k++) begin
            pulse(TSEL);
            wait_acks(a0 + k + 1);
        end
        check("R7 five blocks", acks - a0, 5);
        check("R7 data words", data_wr - w0, 10);
        check("R7 never completes", complete, 0);
        check("R7 still busy", busy, 1);
        check("R7 loop data", mem[8'hB5], 32'hA000_0045);
        kill();
        check("R10 idle after abort", busy, 0);
        w0 = data_wr;
        pulse(TSEL);
        repeat (20) @(negedge clk);
        check("R10 no access after abort", data_wr - w0, 0);
    endtask

    task automatic t_pending();
        int a0;
        put_desc(6, 8'h50, 8'hC0, 8, 7);
        put_desc(7, 8'h58, 8'hC8, 8, 0);
        a0 = acks;
        go(6);
        pulse(TSEL);
        repeat (2) @(negedge clk);
        pulse(TSEL);
        wait_acks(a0 + 2);
        check("R8 pending serviced", acks - a0, 2);
        check("R8 complete", complete, 1);
        check("R8 data", mem[8'hCF], 32'hA000_005F);
        check("R9 no overrun single pending", overrun, 0);
        a0 = acks;
        go(6);
        pulse(TSEL);
        repeat (2) @(negedge clk);
        pulse(TSEL);
        repeat (2) @(negedge clk);
        pulse(TSEL);
        check("R9 overrun set", overrun, 1);
        wait_acks(a0 + 2);
        check("R9 overrun sticky", overrun, 1);
        go(6);
        check("R9 start clears overrun", overrun, 0);
        kill();
    endtask

    task automatic t_abort_pending();
        int w0;
        put_desc(4, 8'h40, 8'hB0, 8, 5);
        go(4);
        pulse(TSEL);
        repeat (2) @(negedge clk);
        pulse(TSEL);
        repeat (2) @(negedge clk);
        kill();
        check("R10 abort mid block", busy, 0);
        w0 = data_wr;
        go(4);
        repeat (40) @(negedge clk);
        check("R10 pending cleared", data_wr - w0, 0);
        kill();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_trigger();
        t_chain();
        t_loop();
        t_pending();
        t_abort_pending();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule